// File: doc/BRIEF.md
# Time-Triggered Cycle Timer

This block keeps the local time base for time-triggered message scheduling in a CAN controller. A 16-bit counter advances once per prescaled tick while the run bit is set. Three events clear it: the counter wrapping past all ones, a match against one of two compare registers, and an external pulse that reports a matching CAN identifier. After a clear the counter does not restart at zero. It restarts at a programmable local offset.

A match on compare register 0 marks the end of a basic cycle. It also advances a 4-bit cycle number, which a scheduler uses to pick the row of its transmission matrix. The block brings out the live count and the cycle number. It also gives a one-cycle pulse for every clear and a one-cycle pulse for every change of the cycle number. Software reaches all settings through a small single-cycle register port, and reads have no side effects. The block also holds a drift-correction value, capped at its legal maximum, for the bit-timing logic that uses it.

Top module: `tt_cycle_timer`

## Requirements
- R1: After reset, the count, the cycle number, every register and both pulses are 0.
- R2: When ctrl bit 0 (run) is 1, the count rises by one on each cycle with `tick_en` high. It holds when `tick_en` is low or run is 0.
- R3: An `id_match` pulse loads the count from the local offset on the next edge, whatever the state of `tick_en` and run.
- R4: A counted tick while the count is all ones loads the offset, and the cycle number is unchanged.
- R5: When ctrl bit 1 is set, a counted tick with count equal to compare 0 loads the offset and adds one to the cycle number. The cycle number wraps from 15 to 0.
- R6: When ctrl bit 2 is set, a counted tick with count equal to compare 1 loads the offset and leaves the cycle number unchanged.
- R7: When several clear sources occur in one cycle, the result is a single load of the offset, never offset+1. The cycle number advances if compare 0 is among the sources.
- R8: A write to the cycle register in the same cycle as an increment wins. The written value is kept.
- R9: The cycle register reads bits 15:4 as 0 and ignores writes to them.
- R10: The drift register stores written values up to 0x8000. A larger value is stored as 0x8000.
- R11: `clr_pulse` is high for exactly the one cycle after each load of the offset. `cyc_pulse` is high for the one cycle after the cycle number changes, whether by increment or by write.
- R12: Address map: 0 ctrl, 1 offset, 2 drift, 3 compare 0, 4 compare 1, 5 cycle, 6 count (read only). Any other address reads 0. Reading the count changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Prescaled timer tick |
| id_match | input | 1 | External CAN-identifier match pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data (combinational) |
| count | output | 16 | Live timer value |
| cycle | output | 4 | Basic-cycle number |
| clr_pulse | output | 1 | One-cycle pulse after each clear |
| cyc_pulse | output | 1 | One-cycle pulse after the cycle number changes |

## Verification
On every cycle, the assertions check these properties:
- a clear pulse always comes with the count equal to the offset as it was before;
- the count holds when there is neither a counted tick nor a clear;
- a compare-0 increment without a write adds exactly one, modulo 16;
- a write to the cycle register is taken as written;
- the upper cycle bits read 0;
- the drift value never exceeds 0x8000.

Some behaviours can only be shown by the bench's scenarios, because they need a whole sequence of steps: reaching all ones and wrapping, walking from 15 to 0, firing two clear sources in one cycle, and checking that a read of the count disturbs nothing.

// File: rtl/tt_cycle_timer.sv
module tt_cycle_timer #(
  parameter int W  = 16,
  parameter int CW = 4,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          id_match,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  output logic [W-1:0]  count,
  output logic [CW-1:0] cycle,
  output logic          clr_pulse,
  output logic          cyc_pulse
);

  localparam logic [W-1:0]  DRIFT_MAX = W'(1) << (W-1);
  localparam logic [W-1:0]  ALL_ONES  = '1;
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_OFFS = AW'(1);
  localparam logic [AW-1:0] A_DRFT = AW'(2);
  localparam logic [AW-1:0] A_CMP0 = AW'(3);
  localparam logic [AW-1:0] A_CMP1 = AW'(4);
  localparam logic [AW-1:0] A_CYC  = AW'(5);
  localparam logic [AW-1:0] A_CNT  = AW'(6);

  logic [2:0]    ctrl_q;
  logic [W-1:0]  off_q, drift_q, cmp0_q, cmp1_q, cnt_q;
  logic [CW-1:0] cyc_q;
  logic          clr_q, cycp_q;

  wire tick_go = tick_en & ctrl_q[0];
  wire ovf     = tick_go & (cnt_q == ALL_ONES);
  wire hit0    = tick_go & ctrl_q[1] & (cnt_q == cmp0_q);
  wire hit1    = tick_go & ctrl_q[2] & (cnt_q == cmp1_q);
  wire reload  = id_match | ovf | hit0 | hit1;
  wire cyc_wr  = reg_wr & (reg_addr == A_CYC);
  wire cyc_chg = cyc_wr ? (reg_wdata[CW-1:0] != cyc_q) : hit0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      off_q   <= '0;
      drift_q <= '0;
      cmp0_q  <= '0;
      cmp1_q  <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_CTRL:  ctrl_q  <= reg_wdata[2:0];
        A_OFFS:  off_q   <= reg_wdata;
        A_DRFT:  drift_q <= (reg_wdata > DRIFT_MAX) ? DRIFT_MAX : reg_wdata;
        A_CMP0:  cmp0_q  <= reg_wdata;
        A_CMP1:  cmp1_q  <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cyc_q  <= '0;
      clr_q  <= 1'b0;
      cycp_q <= 1'b0;
    end else begin
      if (reload)       cnt_q <= off_q;
      else if (tick_go) cnt_q <= cnt_q + 1'b1;
      if (cyc_wr)       cyc_q <= reg_wdata[CW-1:0];
      else if (hit0)    cyc_q <= cyc_q + 1'b1;
      clr_q  <= reload;
      cycp_q <= cyc_chg;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata = W'(ctrl_q);
      A_OFFS:  reg_rdata = off_q;
      A_DRFT:  reg_rdata = drift_q;
      A_CMP0:  reg_rdata = cmp0_q;
      A_CMP1:  reg_rdata = cmp1_q;
      A_CYC:   reg_rdata = W'(cyc_q);
      A_CNT:   reg_rdata = cnt_q;
      default: reg_rdata = '0;
    endcase
  end

  assign count     = cnt_q;
  assign cycle     = cyc_q;
  assign clr_pulse = clr_q;
  assign cyc_pulse = cycp_q;

  assert_reload_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |-> count == $past(off_q));

  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && !tick_go) |=> $stable(count));

  assert_cycle_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit0 && !cyc_wr) |=> cycle == CW'($past(cycle) + 1'b1));

  assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_wr |=> cycle == $past(reg_wdata[CW-1:0]));

  assert_cyc_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_CYC) |-> reg_rdata[W-1:CW] == '0);

  assert_drift_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    drift_q <= DRIFT_MAX);

endmodule

// File: tb/sim_tt_cycle_timer.sv
module sim_tt_cycle_timer;
  localparam int CLK_NS = 10;

  logic        clk = 0, rst_n = 0, tick_en = 0, id_match = 0, reg_wr = 0;
  logic [2:0]  reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata, count;
  logic [3:0]  cycle;
  logic        clr_pulse, cyc_pulse;
  int errors = 0, checks = 0;
  logic [3:0] c0;

  tt_cycle_timer u0 (.clk, .rst_n, .tick_en, .id_match, .reg_wr, .reg_addr,
    .reg_wdata, .reg_rdata, .count, .cycle, .clr_pulse, .cyc_pulse);

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic ticks(int n);
    @(negedge clk); tick_en = 1;
    repeat (n) @(negedge clk);
    tick_en = 0;
  endtask

  task automatic load_id();
    @(negedge clk); id_match = 1;
    @(negedge clk); id_match = 0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 count", count, 0); chk("R1 cycle", cycle, 0);
    chk("R1 pulses", {clr_pulse, cyc_pulse}, 0);
    for (int a = 0; a < 6; a++) begin rd(3'(a), d); chk("R1 reg", d, 0); end
  endtask

  task automatic t_count();
    ticks(5); chk("R2 run off holds", count, 0);
    wr(0, 16'h1); ticks(7); chk("R2 counts", count, 7);
    repeat (3) @(negedge clk); chk("R2 tick low holds", count, 7);
  endtask

  task automatic t_id();
    wr(1, 16'h0100); wr(0, 16'h0);
    load_id();
    chk("R3 id loads offset", count, 16'h0100); chk("R11 clr pulse", clr_pulse, 1);
    @(negedge clk); chk("R11 clr one cycle", clr_pulse, 0);
  endtask

  task automatic t_ovf();
    wr(0, 16'h1); wr(1, 16'hFFF0); load_id();
    ticks(15); chk("R4 reach all ones", count, 16'hFFFF);
    c0 = cycle; ticks(1);
    chk("R4 wrap to offset", count, 16'hFFF0); chk("R11 clr on ovf", clr_pulse, 1);
    chk("R4 cycle kept", cycle, c0); chk("R11 no cyc pulse", cyc_pulse, 0);
  endtask

  task automatic cmp0_evt();
    load_id(); ticks(4); ticks(1);
  endtask

  task automatic t_cmp0();
    wr(1, 16'h0010); wr(3, 16'h0014); wr(0, 16'h3);
    c0 = cycle; cmp0_evt();
    chk("R5 reload", count, 16'h0010); chk("R5 cycle+1", cycle, c0 + 4'd1);
    chk("R11 cyc pulse", cyc_pulse, 1);
    wr(5, 16'h000F); cmp0_evt(); chk("R5 wrap 15 to 0", cycle, 0);
  endtask

  task automatic t_cmp1();
    wr(4, 16'h0012); wr(0, 16'h5);
    c0 = cycle; load_id(); ticks(2); ticks(1);
    chk("R6 reload", count, 16'h0010); chk("R6 cycle kept", cycle, c0);
    chk("R6 clr pulse", clr_pulse, 1);
  endtask

  task automatic t_both();
    wr(0, 16'h3); c0 = cycle; load_id(); ticks(4);
    @(negedge clk); tick_en = 1; id_match = 1;
    @(negedge clk); tick_en = 0; id_match = 0;
    chk("R7 single reload", count, 16'h0010); chk("R7 cycle+1", cycle, c0 + 4'd1);
  endtask

  task automatic t_prio();
    load_id(); ticks(4);
    @(negedge clk); tick_en = 1; reg_wr = 1; reg_addr = 5; reg_wdata = 16'h0009;
    @(negedge clk); tick_en = 0; reg_wr = 0;
    chk("R8 write wins", cycle, 9); chk("R8 still reloads", count, 16'h0010);
  endtask

  task automatic t_regs();
    logic [15:0] d, e;
    wr(5, 16'hFFF6); rd(5, d); chk("R9 upper zero", d, 16'h0006);
    wr(2, 16'h9000); rd(2, d); chk("R10 clamp", d, 16'h8000);
    wr(2, 16'h8000); rd(2, d); chk("R10 at limit", d, 16'h8000);
    wr(2, 16'h1234); rd(2, d); chk("R10 below", d, 16'h1234);
    rd(6, d); rd(6, e); chk("R12 count read stable", e, d); chk("R12 count match", d, count);
    rd(7, d); chk("R12 unused addr", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk); rst_n = 1; @(negedge clk);
    t_reset(); t_count(); t_id(); t_ovf(); t_cmp0(); t_cmp1(); t_both(); t_prio(); t_regs();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule